// File: doc/BRIEF.md
# Selectable Audio Sample Clock Generator

This block produces the sample strobe that paces a stereo converter. Four timing sources are available. Three are on-board crystal oscillators, each presented to the block as a one-cycle enable pulse in the system clock domain. The fourth is an asynchronous TTL-level external clock. A two-bit rate select picks one source. An internal oscillator is divided by 128. The external clock runs at eight times the sample rate, so it is divided by 8. The result is a strobe one system clock wide at the chosen sample rate.

Software starts and stops the generator with a run enable, and a status output reports whether it is running. A 2x oversampling request halves the division ratio. The request is honoured only when exactly one of the two channels is enabled. With both channels enabled the request is ignored and a configuration error flag is raised. Any change of source or effective division clears the divider, so the first strobe after a change always comes one full new period later.

Top module: `sample_clk_gen`

## Requirements
- R1: During and right after reset, `sampleStrobe`, `oscRunning` and `cfgError` are all 0.
- R2: With `oscRun`=1, `rateSel` 00, 01 and 10 select `oscTick[0]`, `oscTick[1]` and `oscTick[2]`. One strobe is issued for every 128 pulses of the selected oscillator.
- R3: With `rateSel`=11, `extClk` passes through a two-flop synchroniser. One strobe is issued for every 8 rising edges of `extClk`.
- R4: While `oscRun`=0, no strobe is issued and the divider is held cleared. `oscRunning` equals the value `oscRun` had one clock earlier.
- R5: In the cycle after `rateSel` changes, no strobe is issued. The first strobe after the change comes only after a full period of the new source: at least 127 and at most 128 of its ticks.
- R6: `sampleStrobe` is never high in two consecutive cycles.
- R7: When `overSample`=1 and exactly one bit of `chanEn` is set, the divisor becomes 64 for an oscillator and 4 for the external clock. `cfgError` stays 0.
- R8: When `overSample`=1 and `chanEn`=11, the request is ignored and the full-rate divisor stays in use. `cfgError` is 1 from the next cycle on.
- R9: When `overSample`=1 and `chanEn`=00, the request is ignored and `cfgError` stays 0.
- R10: When `oscRun` goes from 0 to 1, the first strobe comes after a full period of the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscTick | input | 3 | One-cycle enable pulses, one per internal oscillator |
| extClk | input | 1 | Asynchronous external clock at 8x the sample rate |
| rateSel | input | 2 | Source select: 00, 01, 10 oscillators, 11 external |
| oscRun | input | 1 | 1 runs the generator, 0 stops it |
| overSample | input | 1 | Request 2x oversampling |
| chanEn | input | 2 | Channel enables {left, right} |
| sampleStrobe | output | 1 | One-cycle sample strobe |
| oscRunning | output | 1 | Running status |
| cfgError | output | 1 | Oversampling requested with both channels enabled |

## Verification
The embedded assertions check several properties on every cycle: the strobe is one cycle wide, it never follows a cycle in which the generator was stopped, it is suppressed right after a source change, the divider count stays below the active limit, and an oversampling request with both channels on never reaches the datapath. The actual division ratios can only be seen through the directed scenarios: 128 per oscillator pulse, 8 per external edge, and the halved ratios. The same holds for the one-full-period latency after a source change or a restart. Each scenario measures strobe spacing against bench-side oscillator models with known periods.

// File: rtl/sample_clk_pkg.sv
package sample_clk_pkg;
  localparam int NUM_OSC = 3;
  localparam logic [1:0] SEL_EXT = 2'b11;

  typedef struct packed {
    logic clear;
    logic countEn;
    logic isExt;
    logic halfRate;
  } genCtl_t;
endpackage

// File: rtl/sample_clk_ctrl.sv
module sample_clk_ctrl
  import sample_clk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_OSC-1:0] oscTick,
  input  logic               extClk,
  input  logic [1:0]         rateSel,
  input  logic               oscRun,
  input  logic               overSample,
  input  logic [1:0]         chanEn,
  output genCtl_t            ctl,
  output logic               oscRunning,
  output logic               cfgError
);
  logic [SYNC_STAGES:0] extPipe;
  logic extRise;
  logic halfOk;
  logic bothOn;
  logic tickSel;
  logic modeChange;
  logic [1:0] selQ;
  logic halfQ;
  logic runQ;
  logic errQ;

  // Synchroniser stages plus one extra flop for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) extPipe <= '0;
    else       extPipe <= {extPipe[SYNC_STAGES-1:0], extClk};
  end
  assign extRise = extPipe[SYNC_STAGES-1] & ~extPipe[SYNC_STAGES];

  assign bothOn = chanEn[0] & chanEn[1];
  assign halfOk = overSample & (chanEn[0] ^ chanEn[1]);

  always_comb begin
    tickSel = 1'b0;
    if (rateSel == SEL_EXT) tickSel = extRise;
    else begin
      for (int i = 0; i < NUM_OSC; i++)
        if (rateSel == i[1:0]) tickSel = oscTick[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= '0;
      halfQ <= 1'b0;
      runQ  <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      selQ  <= rateSel;
      halfQ <= halfOk;
      runQ  <= oscRun;
      errQ  <= overSample & bothOn;
    end
  end

  assign modeChange = (rateSel != selQ) || (halfOk != halfQ);

  assign ctl.clear    = ~oscRun | modeChange;
  assign ctl.countEn  = oscRun & tickSel;
  assign ctl.isExt    = (rateSel == SEL_EXT);
  assign ctl.halfRate = halfOk;

  assign oscRunning = runQ;
  assign cfgError   = errQ;

  AST_HALF_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (overSample && bothOn) |-> !ctl.halfRate); // R8
  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    !oscRun |-> !ctl.countEn); // R4
endmodule

// File: rtl/sample_clk_div.sv
module sample_clk_div
  import sample_clk_pkg::*;
#(
  parameter int INT_DIV = 128,
  parameter int EXT_DIV = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  genCtl_t ctl,
  output logic    strobe
);
  localparam int CNT_W    = $clog2(INT_DIV);
  localparam int INT_HALF = INT_DIV / 2;
  localparam int EXT_HALF = EXT_DIV / 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastIdx;
  logic strobeQ;

  always_comb begin
    unique case ({ctl.isExt, ctl.halfRate})
      2'b00:   lastIdx = CNT_W'(INT_DIV - 1);
      2'b01:   lastIdx = CNT_W'(INT_HALF - 1);
      2'b10:   lastIdx = CNT_W'(EXT_DIV - 1);
      default: lastIdx = CNT_W'(EXT_HALF - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      cnt     <= '0;
      strobeQ <= 1'b0;
    end else if (ctl.countEn) begin
      if (cnt >= lastIdx) begin
        cnt     <= '0;
        strobeQ <= 1'b1;
      end else begin
        cnt     <= cnt + 1'b1;
        strobeQ <= 1'b0;
      end
    end else begin
      strobeQ <= 1'b0;
    end
  end

  assign strobe = strobeQ;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.clear |-> cnt <= lastIdx); // R2
  AST_STROBE_FROM_TICK: assert property (@(posedge clk) disable iff (!rstN)
    strobeQ |-> $past(ctl.countEn)); // R2
endmodule

// File: rtl/sample_clk_gen.sv
module sample_clk_gen
  import sample_clk_pkg::*;
#(
  parameter int INT_DIV     = 128,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] oscTick,
  input  logic       extClk,
  input  logic [1:0] rateSel,
  input  logic       oscRun,
  input  logic       overSample,
  input  logic [1:0] chanEn,
  output logic       sampleStrobe,
  output logic       oscRunning,
  output logic       cfgError
);
  genCtl_t ctl;

  sample_clk_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .extClk(extClk),
    .rateSel(rateSel), .oscRun(oscRun), .overSample(overSample),
    .chanEn(chanEn), .ctl(ctl), .oscRunning(oscRunning), .cfgError(cfgError)
  );

  sample_clk_div #(.INT_DIV(INT_DIV), .EXT_DIV(EXT_DIV)) uDiv (
    .clk(clk), .rstN(rstN), .ctl(ctl), .strobe(sampleStrobe)
  );

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> !sampleStrobe); // R6
  AST_NO_STROBE_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> $past(oscRun)); // R4
  AST_QUIET_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (rateSel != $past(rateSel)) |=> !sampleStrobe); // R5
endmodule

// File: tb/sim_sample_clk_gen.sv
module sim_sample_clk_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] oscTick = '0;
  logic extClk = 1'b0;
  logic [1:0] rateSel = 2'b00;
  logic oscRun = 1'b0;
  logic overSample = 1'b0;
  logic [1:0] chanEn = 2'b01;
  logic sampleStrobe, oscRunning, cfgError;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  sample_clk_gen u0 (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .extClk(extClk),
    .rateSel(rateSel), .oscRun(oscRun), .overSample(overSample),
    .chanEn(chanEn), .sampleStrobe(sampleStrobe), .oscRunning(oscRunning),
    .cfgError(cfgError)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Oscillator models: osc0 every 2 cycles, osc1 every 3, osc2 every 4; extClk period 6
  always @(negedge clk) begin
    cyc <= cyc + 1;
    oscTick <= {(cyc % 4 == 0), (cyc % 3 == 0), (cyc % 2 == 0)};
    if (cyc % 3 == 0) extClk <= ~extClk;
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual=expired expected=done");
    finishRun();
  end

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic checkRange(string req, int actual, int lo, int hi);
    checks++;
    if (actual < lo || actual > hi) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, actual, lo, hi);
    end
  endtask

  // Negedges until strobe is seen (returns -1 on timeout)
  task automatic waitStrobe(int limit, output int n);
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n > limit) begin n = -1; return; end
    end while (!sampleStrobe);
  endtask

  task automatic measureGap(output int gap);
    int dummy;
    waitStrobe(3000, dummy);
    waitStrobe(3000, gap);
  endtask

  task automatic tReset();
    @(negedge clk);
    check("R1 strobe in reset", sampleStrobe, 0);
    check("R1 running in reset", oscRunning, 0);
    check("R1 cfgError in reset", cfgError, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 strobe after reset", sampleStrobe, 0);
    check("R1 running after reset", oscRunning, 0);
  endtask

  task automatic tRates();
    int gap;
    int period;
    oscRun = 1'b1;
    @(negedge clk);
    check("R4 running status", oscRunning, 1);
    for (int s = 0; s < 3; s++) begin
      rateSel = 2'(s);
      period = s + 2;
      measureGap(gap);
      check("R2 oscillator divide by 128", gap, 128 * period);
      @(negedge clk);
      check("R6 strobe single cycle", sampleStrobe, 0);
    end
  endtask

  task automatic tExt();
    int gap;
    rateSel = 2'b11;
    measureGap(gap);
    check("R3 external divide by 8", gap, 8 * 6);
    @(negedge clk);
    check("R6 strobe single cycle ext", sampleStrobe, 0);
  endtask

  task automatic tStopResume();
    int seen;
    int n;
    rateSel = 2'b00;
    measureGap(n);
    oscRun = 1'b0;
    @(negedge clk);
    check("R4 status low after stop", oscRunning, 0);
    seen = 0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (sampleStrobe) seen++;
    end
    check("R4 no strobe while stopped", seen, 0);
    oscRun = 1'b1;
    waitStrobe(3000, n);
    checkRange("R10 full period after restart", n, 127 * 2 + 1, 128 * 2 + 1);
  endtask

  task automatic tChange();
    int n;
    rateSel = 2'b00;
    waitStrobe(3000, n);
    repeat (100) @(negedge clk);
    rateSel = 2'b10;
    @(negedge clk);
    check("R5 no strobe after change", sampleStrobe, 0);
    waitStrobe(3000, n);
    checkRange("R5 full new period", n + 1, 127 * 4 + 1, 128 * 4 + 1);
  endtask

  task automatic tOversample();
    int gap;
    rateSel = 2'b01;
    chanEn = 2'b10;
    overSample = 1'b1;
    measureGap(gap);
    check("R7 oversample osc divide by 64", gap, 64 * 3);
    check("R7 no cfgError one channel", cfgError, 0);
    rateSel = 2'b11;
    measureGap(gap);
    check("R7 oversample ext divide by 4", gap, 4 * 6);
    rateSel = 2'b01;
    chanEn = 2'b11;
    @(negedge clk);
    check("R8 cfgError raised", cfgError, 1);
    measureGap(gap);
    check("R8 request ignored both channels", gap, 128 * 3);
    chanEn = 2'b00;
    @(negedge clk);
    check("R9 cfgError clear no channel", cfgError, 0);
    measureGap(gap);
    check("R9 request ignored no channel", gap, 128 * 3);
    overSample = 1'b0;
    chanEn = 2'b01;
  endtask

  initial begin
    tReset();
    tRates();
    tExt();
    tStopResume();
    tChange();
    tOversample();
    finishRun();
  end
endmodule